// File: doc/BRIEF.md
# Motor Stall Protection Supervisor

This block watches a running motor and removes high-side drive when the motor appears stalled or constrained. In the start state it times how long the chosen health criterion has been missing, in system-clock ticks. When that time reaches a programmable limit, a fault latches and the drive enable drops. The fault stays latched until the start/stop input is taken to stop and back to start, or until a power reset.

The criterion is selected by a single input. In feedback mode the speed feedback pulse must keep toggling. In lock mode the speed loop's lock flag must be asserted. In lock mode the block also measures the period of the speed reference. When the reference period changes, the timer restarts, so a commanded slow-down does not trip the fault. A missing reference leaves the motor unlocked with a steady (absent) reference, so the fault trips and acts as clock-loss protection.

All level and pulse inputs pass through a synchronizer chain before use. Both outputs are registered.

Top module: `stall_guard`

## Requirements
- R1: A high level on `stop_lvl` is the stop state. In stop, `drive_en` is low, `fault` is low and the stall timer is held at zero. After reset the block is in stop with both outputs low.
- R2: In the start state (`stop_lvl` low) with no fault, `drive_en` is high. It rises within SYNC_STAGES+2 cycles of entering start.
- R3: With `crit_sel` low (feedback mode), the fault sets once `fb_in` shows no edge, rising or falling, for `timeout` consecutive start-state cycles. Every feedback edge restarts the timer. `lock_in` has no effect in this mode.
- R4: With `crit_sel` high (lock mode), the fault sets once `lock_in` stays low for `timeout` consecutive start-state cycles. While `lock_in` is high the timer is held at zero. `fb_in` has no effect in this mode.
- R5: In lock mode, each rising edge of `ref_in` ends a measured reference period. If that period differs from the previous one by more than TOL ticks, the timer restarts. A reference whose period keeps changing therefore never trips the fault.
- R6: In lock mode with `ref_in` absent and `lock_in` low, the fault sets after `timeout` cycles.
- R7: Once set, `fault` stays high for as long as the start state lasts, whatever the criterion inputs do. While `fault` is high, `drive_en` is low.
- R8: A stop followed by a start clears the fault and restores `drive_en`.
- R9: A `timeout` value of zero disables tripping.
- R10: A change of `crit_sel` restarts the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| stop_lvl | input | 1 | High = stop, low = start |
| crit_sel | input | 1 | High = lock criterion, low = feedback criterion |
| fb_in | input | 1 | Speed feedback pulse |
| lock_in | input | 1 | High while the speed loop is locked |
| ref_in | input | 1 | Speed reference pulse |
| timeout | input | CNT_W | Stall limit in clock ticks, 0 disables |
| drive_en | output | 1 | High-side drive enable |
| fault | output | 1 | Latched stall fault |

## Verification
The bench stops the feedback pulse and checks two things: the fault must not set before the limit, and it must set shortly after. A timer that ignored feedback edges, or counted only one edge polarity at the wrong rate, would trip early or never. It restarts feedback after a trip to confirm the fault does not self-clear. It then holds stop for a long time to confirm that the timer does not build up while stopped. In lock mode it alternates the reference period while unlocked: a design without period-change restart would fault during a legitimate slow-down. It also removes the reference entirely, which must still trip. Finally, it switches criterion part-way through a stall window and uses a zero limit; a design that kept the old count or treated zero as one cycle would fault at once.

// File: rtl/stall_pkg.sv
package stall_pkg;

    typedef enum logic {
        CRIT_FEEDBACK = 1'b0,
        CRIT_LOCK     = 1'b1
    } crit_t;

    typedef struct packed {
        logic  fault;
        logic  drive_en;
        crit_t sel_prev;
    } guard_st_t;

endpackage

// File: rtl/sg_sync_edge.sv
module sg_sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic any_edge,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= RST_VAL;
                end else if (g == 0) begin
                    chain_q[g] <= din;
                end else begin
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= chain_q[STAGES-1];
    end

    always_comb begin
        level    = chain_q[STAGES-1];
        any_edge = chain_q[STAGES-1] ^ prev_q;
        rise     = chain_q[STAGES-1] & ~prev_q;
    end
endmodule

// File: rtl/sg_period_mon.sv
module sg_period_mon #(
    parameter int PER_W = 16,
    parameter int TOL   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    output logic changed
);
    localparam logic [PER_W-1:0] TOL_V = PER_W'(TOL);

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] last;
        logic             valid;
    } per_st_t;

    per_st_t st_d, st_q;
    logic [PER_W-1:0] diff;

    always_comb begin
        st_d    = st_q;
        changed = 1'b0;
        diff    = (st_q.cnt >= st_q.last) ? (st_q.cnt - st_q.last)
                                          : (st_q.last - st_q.cnt);
        if (rise) begin
            changed    = st_q.valid && (diff > TOL_V);
            st_d.last  = st_q.cnt;
            st_d.cnt   = '0;
            st_d.valid = 1'b1;
        end else if (st_q.cnt != '1) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sg_stall_timer.sv
module sg_stall_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && !clear && (limit != '0) && (cnt_q >= limit - ONE);
        if (!run || clear)       cnt_d = '0;
        else if (cnt_q != '1)    cnt_d = cnt_q + ONE;
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/stall_guard.sv
module stall_guard
    import stall_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PER_W       = 16,
    parameter int TOL         = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_lvl,
    input  logic             crit_sel,
    input  logic             fb_in,
    input  logic             lock_in,
    input  logic             ref_in,
    input  logic [CNT_W-1:0] timeout,
    output logic             drive_en,
    output logic             fault
);
    logic stop_s, stop_e, stop_r;
    logic sel_s, sel_e, sel_r;
    logic lock_s, lock_e, lock_r;
    logic fb_s, fb_edge, fb_r;
    logic ref_s, ref_e, ref_rise;
    logic ref_changed, restart, expire, run_s;
    crit_t sel_c;

    guard_st_t st_d, st_q;

    sg_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stop (
        .clk(clk), .rst_n(rst_n), .din(stop_lvl),
        .level(stop_s), .any_edge(stop_e), .rise(stop_r));

    sg_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel (
        .clk(clk), .rst_n(rst_n), .din(crit_sel),
        .level(sel_s), .any_edge(sel_e), .rise(sel_r));

    sg_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lock (
        .clk(clk), .rst_n(rst_n), .din(lock_in),
        .level(lock_s), .any_edge(lock_e), .rise(lock_r));

    sg_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_fb (
        .clk(clk), .rst_n(rst_n), .din(fb_in),
        .level(fb_s), .any_edge(fb_edge), .rise(fb_r));

    sg_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ref (
        .clk(clk), .rst_n(rst_n), .din(ref_in),
        .level(ref_s), .any_edge(ref_e), .rise(ref_rise));

    sg_period_mon #(.PER_W(PER_W), .TOL(TOL)) u_per (
        .clk(clk), .rst_n(rst_n), .rise(ref_rise), .changed(ref_changed));

    sg_stall_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(run_s), .clear(restart),
        .limit(timeout), .expire(expire));

    always_comb begin
        run_s = ~stop_s;
        sel_c = crit_t'(sel_s);
        unique case (sel_c)
            CRIT_LOCK:     restart = lock_s | ref_changed;
            CRIT_FEEDBACK: restart = fb_edge;
            default:       restart = 1'b1;
        endcase
        restart = restart | (sel_c != st_q.sel_prev) | st_q.fault;

        st_d          = st_q;
        st_d.sel_prev = sel_c;
        st_d.fault    = run_s & (st_q.fault | expire);
        st_d.drive_en = run_s & ~st_d.fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fault    <= 1'b0;
            st_q.drive_en <= 1'b0;
            st_q.sel_prev <= CRIT_LOCK;
        end else begin
            st_q <= st_d;
        end
    end

    assign drive_en = st_q.drive_en;
    assign fault    = st_q.fault;
endmodule

// File: rtl/stall_guard_chk.sv
module stall_guard_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_s,
    input logic             fault,
    input logic             drive_en,
    input logic [CNT_W-1:0] limit
);
    p_fault_cuts_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !drive_en);

    p_fault_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && run_s) |=> fault);

    p_stop_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_s |=> (!fault && !drive_en));

    p_trip_in_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(run_s));

    p_zero_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> ($past(limit) != '0));

    p_drive_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> $past(run_s));
endmodule

bind stall_guard stall_guard_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_s(run_s),
    .fault(fault), .drive_en(drive_en), .limit(timeout));

// File: tb/sim_stall_guard.sv
`timescale 1ns/1ps
module sim_stall_guard;
    localparam int CNT_W = 16;
    localparam int LIM   = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_lvl = 1'b1;
    logic crit_sel = 1'b0;
    logic fb_in = 1'b0;
    logic lock_in = 1'b0;
    logic ref_in = 1'b0;
    logic [CNT_W-1:0] timeout = CNT_W'(LIM);
    logic drive_en, fault;

    int n_tests = 0;
    int n_fail  = 0;

    int fb_half = 0;
    int fb_cnt  = 0;
    int ref_per = 20;
    int ref_cnt = 0;
    int ref_cur = 20;
    logic ref_alt = 1'b0;
    logic ref_flip = 1'b0;

    always #2 clk = ~clk;

    stall_guard #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .stop_lvl(stop_lvl), .crit_sel(crit_sel),
        .fb_in(fb_in), .lock_in(lock_in), .ref_in(ref_in),
        .timeout(timeout), .drive_en(drive_en), .fault(fault));

    always @(negedge clk) begin
        if (fb_half == 0) fb_cnt <= 0;
        else if (fb_cnt >= fb_half - 1) begin
            fb_in  <= ~fb_in;
            fb_cnt <= 0;
        end else fb_cnt <= fb_cnt + 1;
    end

    always @(negedge clk) begin
        if (ref_per == 0) begin
            ref_in  <= 1'b0;
            ref_cnt <= 0;
        end else if (ref_cnt >= ref_cur - 1) begin
            ref_in   <= 1'b1;
            ref_cnt  <= 0;
            ref_flip <= ~ref_flip;
            ref_cur  <= (ref_alt && !ref_flip) ? ref_per + 10 : ref_per;
        end else begin
            ref_in  <= 1'b0;
            ref_cnt <= ref_cnt + 1;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic stop_cycle();
        stop_lvl = 1'b1;
        wait_cyc(6);
        stop_lvl = 1'b0;
    endtask

    task automatic t_reset();
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        chk("R1", "reset fault", fault, 1'b0);
        chk("R1", "reset drive_en", drive_en, 1'b0);
    endtask

    task automatic t_fb_running();
        crit_sel = 1'b0; lock_in = 1'b0; fb_half = 10;
        stop_lvl = 1'b0;
        wait_cyc(5);
        chk("R2", "drive_en after start", drive_en, 1'b1);
        wait_cyc(500);
        chk("R3", "no fault while feedback toggles, lock low", fault, 1'b0);
        chk("R2", "drive_en held", drive_en, 1'b1);
    endtask

    task automatic t_fb_stall();
        fb_half = 0;
        wait_cyc(80);
        chk("R3", "no fault before limit", fault, 1'b0);
        wait_cyc(40);
        chk("R3", "fault after feedback stops", fault, 1'b1);
        chk("R7", "drive_en cut by fault", drive_en, 1'b0);
    endtask

    task automatic t_latch_release();
        fb_half = 10;
        wait_cyc(300);
        chk("R7", "fault latched despite feedback", fault, 1'b1);
        chk("R7", "drive_en stays low", drive_en, 1'b0);
        stop_lvl = 1'b1;
        wait_cyc(6);
        chk("R1", "stop clears fault", fault, 1'b0);
        chk("R1", "stop drive_en low", drive_en, 1'b0);
        stop_lvl = 1'b0;
        wait_cyc(6);
        chk("R8", "restart drive_en", drive_en, 1'b1);
        chk("R8", "restart fault low", fault, 1'b0);
    endtask

    task automatic t_lock_mode();
        crit_sel = 1'b1; lock_in = 1'b1; fb_half = 0;
        wait_cyc(500);
        chk("R4", "locked, no feedback: no fault", fault, 1'b0);
        lock_in = 1'b0;
        wait_cyc(80);
        chk("R4", "unlock before limit", fault, 1'b0);
        wait_cyc(50);
        chk("R4", "unlock trips", fault, 1'b1);
    endtask

    task automatic t_clock_loss();
        ref_per = 0;
        stop_cycle();
        wait_cyc(80);
        chk("R6", "no reference before limit", fault, 1'b0);
        wait_cyc(50);
        chk("R6", "no reference trips", fault, 1'b1);
        ref_per = 20;
    endtask

    task automatic t_decel();
        ref_alt = 1'b1;
        stop_cycle();
        wait_cyc(600);
        chk("R5", "changing reference period, unlocked: no fault", fault, 1'b0);
        ref_alt = 1'b0;
        wait_cyc(300);
        chk("R5", "steady reference, unlocked: trips", fault, 1'b1);
    endtask

    task automatic t_zero_limit();
        crit_sel = 1'b0; fb_half = 0; timeout = '0;
        stop_cycle();
        wait_cyc(400);
        chk("R9", "zero limit never trips", fault, 1'b0);
        chk("R9", "zero limit drive_en", drive_en, 1'b1);
        timeout = CNT_W'(LIM);
    endtask

    task automatic t_stop_hold();
        stop_lvl = 1'b1;
        wait_cyc(500);
        chk("R1", "long stop no fault", fault, 1'b0);
        chk("R1", "long stop drive_en low", drive_en, 1'b0);
        stop_lvl = 1'b0;
        wait_cyc(80);
        chk("R1", "timer not accumulated in stop", fault, 1'b0);
        wait_cyc(40);
        chk("R3", "trips after full limit", fault, 1'b1);
    endtask

    task automatic t_switch();
        crit_sel = 1'b0; fb_half = 0; lock_in = 1'b0;
        stop_cycle();
        wait_cyc(80);
        crit_sel = 1'b1;
        wait_cyc(80);
        chk("R10", "criterion change restarted timer", fault, 1'b0);
        wait_cyc(50);
        chk("R10", "trips after new window", fault, 1'b1);
    endtask

    initial begin
        t_reset();
        t_fb_running();
        t_fb_stall();
        t_latch_release();
        t_lock_mode();
        t_clock_loss();
        t_decel();
        t_zero_limit();
        t_stop_hold();
        t_switch();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule